// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block issues one SD card command each time software writes the command register with its start bit set. It presents the six-bit command index and the 32-bit argument to a card-side request/response handshake. It waits for the reply and checks that the reply length matches the response type the command asked for. A good reply is stored in four 32-bit response words. A raw status word records whether the command completed or got no valid response.

A command may carry a data phase. The block then hands control to an external DMA engine through a start/done handshake, and resumes when the engine reports completion. When the command requests an automatic stop and the external remaining-transfer count is zero, the block follows the user command with a stop command of its own: index 12 with a zero argument. The programmed command and argument are left as they were. A command flagged as clock-change only finishes without touching the card interface. A busy output covers the whole sequence, and command or argument writes that arrive while busy are discarded.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: The command word is decoded as: bits 5:0 index, bit 6 response expected, bit 7 long response, bit 9 data phase, bit 12 automatic stop, bit 21 clock-change only, bit 31 start. An issued request carries bits 5:0 as `reqIndex` and the stored argument as `reqArg`.
- R2: After a start is accepted, the stored command reads back with bit 31 clear and all other bits unchanged.
- R3: A command with bit 21 set raises no request on the card interface and still sets command-complete (status bit 2).
- R4: With bit 6 set and bit 7 clear, a 4-byte reply is stored with its first byte as the most significant byte of response word 0 (`respWords[31:0]`). Words 1 to 3 are cleared. Reply byte k arrives on `rspData[127-8k -: 8]`.
- R5: With bits 6 and 7 set, a 16-byte reply is stored word-reversed: word 3 (`respWords[127:96]`) holds reply bytes 0..3, and word 0 holds bytes 12..15. Each word is big-endian.
- R6: A reply flagged as an error, or one whose length does not match the response type, sets no-response (status bit 1) instead of command-complete, and leaves the response words unchanged.
- R7: With bit 12 set and `xferCount` equal to zero, a second request with index 12 and argument 0 follows. On its completion status bit 14 is set. The stored command and argument are unchanged afterwards. With a non-zero count, no stop is issued.
- R8: A started command runs its steps in a fixed order: the user request first, then the DMA handshake if bit 9 is set, then the automatic-stop decision.
- R9: `busy` is high from the cycle after a start is written until the sequence ends. Command and argument writes made while busy are ignored.
- R10: A request that gets no reply within `RSP_TIMEOUT` cycles ends with status bit 1 set.
- R11: Status bits are cleared by writing ones through `statusClrEn`/`statusClrMask`. After reset, all status bits, response words, command and argument are zero.
- R12: A command with bit 6 clear completes with status bit 2 on any error-free reply length, and leaves the response words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 32 | Command register write value |
| argWrEn | input | 1 | Argument register write strobe |
| argWrData | input | 32 | Argument register write value |
| xferCount | input | XFER_W | Remaining data transfer count from the data path |
| statusClrEn | input | 1 | Status write-one-to-clear strobe |
| statusClrMask | input | 32 | Bits of raw status to clear |
| reqValid | output | 1 | Request to the card interface is pending |
| reqIndex | output | 6 | Command index of the pending request |
| reqArg | output | 32 | Argument of the pending request |
| rspValid | input | 1 | Card interface reply strobe |
| rspErr | input | 1 | Reply carries a bus error |
| rspLen | input | LEN_W | Number of valid reply bytes |
| rspData | input | RSP_W | Reply bytes, first byte in the top bits |
| dmaStart | output | 1 | Data phase request to the DMA engine |
| dmaDone | input | 1 | DMA engine reports the data phase finished |
| cmdReg | output | 32 | Stored command word |
| argReg | output | 32 | Stored argument |
| respWords | output | RSP_W | Response words, word i at bits 32i+31:32i |
| rawStatus | output | 32 | Raw status: bit 1 no-response, bit 2 complete, bit 14 auto-stop done |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that the card side answers only while a request is pending, and that it keeps `rspValid` to a single cycle per request. The bench card model behaves this way: it raises the reply strobe for one cycle after the chosen delay, and drops it on the next falling edge before it looks at a new request. The assertions also assume that the DMA engine asserts `dmaDone` only while `dmaStart` is high. The bench DMA model pulses done a few cycles after it sees start, and never otherwise. Writes are applied on falling clock edges, with one strobe active at a time, so at most one register write reaches each edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_W  = 32;
  localparam int IDX_W  = 6;
  localparam int WORD_W = 32;

  // command word fields
  localparam int CMD_START_BIT = 31;
  localparam int CMD_CLKONLY_BIT = 21;
  localparam int CMD_AUTOSTOP_BIT = 12;
  localparam int CMD_DATA_BIT = 9;
  localparam int CMD_LONG_BIT = 7;
  localparam int CMD_RSP_BIT = 6;

  // raw status fields
  localparam int ST_NORSP_BIT = 1;
  localparam int ST_DONE_BIT = 2;
  localparam int ST_AUTO_BIT = 14;

  localparam logic [IDX_W-1:0] STOP_INDEX = IDX_W'(12);
  localparam int SHORT_BYTES = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_DATA  = 2'd2
  } seqStateT;

  typedef struct packed {
    logic clearLoad;
    logic selStop;
    logic storeRsp;
    logic setDone;
    logic setNoRsp;
    logic setAuto;
  } seqStrobeT;
endpackage

// File: rtl/sdc_seq_ctrl.sv
module sdc_seq_ctrl
  import sdc_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadPending,
  input  logic      clkOnly,
  input  logic      hasData,
  input  logic      autoStop,
  input  logic      xferZero,
  input  logic      rspValid,
  input  logic      rspGood,
  input  logic      dmaDone,
  output seqStrobeT strobe,
  output logic      reqValid,
  output logic      dmaStart,
  output logic      busy
);
  localparam int TMO_W = $clog2(RSP_TIMEOUT + 1);

  seqStateT   state, stateNext;
  logic       inStop, inStopNext;
  logic [TMO_W-1:0] timer;
  logic       rspHit, timeoutHit, issueDone, issueOk, stopNeeded;

  always_comb begin
    reqValid   = (state == SQ_ISSUE) && !clkOnly;
    dmaStart   = (state == SQ_DATA);
    rspHit     = reqValid && rspValid;
    timeoutHit = reqValid && !rspValid && (timer == TMO_W'(RSP_TIMEOUT - 1));
    issueDone  = (state == SQ_ISSUE) && (clkOnly || rspHit || timeoutHit);
    issueOk    = clkOnly || (rspHit && rspGood);
    stopNeeded = autoStop && xferZero;
    busy       = (state != SQ_IDLE) || loadPending;
  end

  always_comb begin
    stateNext      = state;
    inStopNext     = inStop;
    strobe         = '0;
    strobe.selStop = inStop;
    unique case (state)
      SQ_IDLE: begin
        if (loadPending) begin
          strobe.clearLoad = 1'b1;
          stateNext        = SQ_ISSUE;
          inStopNext       = 1'b0;
        end
      end
      SQ_ISSUE: begin
        if (issueDone) begin
          strobe.storeRsp = !clkOnly && rspHit && rspGood;
          strobe.setDone  = issueOk;
          strobe.setNoRsp = !issueOk;
          strobe.setAuto  = inStop;
          if (inStop) begin
            stateNext  = SQ_IDLE;
            inStopNext = 1'b0;
          end else if (hasData) begin
            stateNext = SQ_DATA;
          end else if (stopNeeded) begin
            stateNext  = SQ_ISSUE;
            inStopNext = 1'b1;
          end else begin
            stateNext = SQ_IDLE;
          end
        end
      end
      SQ_DATA: begin
        if (dmaDone) begin
          if (stopNeeded) begin
            stateNext  = SQ_ISSUE;
            inStopNext = 1'b1;
          end else begin
            stateNext = SQ_IDLE;
          end
        end
      end
      default: stateNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SQ_IDLE;
      inStop <= 1'b0;
      timer  <= '0;
    end else begin
      state  <= stateNext;
      inStop <= inStopNext;
      if (reqValid && !issueDone) timer <= timer + 1'b1;
      else                        timer <= '0;
    end
  end
endmodule

// File: rtl/sdc_seq_datapath.sv
module sdc_seq_datapath
  import sdc_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int XFER_W    = 16,
  localparam int RSP_W     = 8 * RSP_BYTES,
  localparam int RSP_WORDS = RSP_BYTES / 4,
  localparam int LEN_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              argWrEn,
  input  logic [WORD_W-1:0] argWrData,
  input  logic              busy,
  input  logic [XFER_W-1:0] xferCount,
  input  seqStrobeT         strobe,
  input  logic              rspErr,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic [RSP_W-1:0]  rspData,
  input  logic              statusClrEn,
  input  logic [CMD_W-1:0]  statusClrMask,
  output logic [CMD_W-1:0]  cmdReg,
  output logic [WORD_W-1:0] argReg,
  output logic [RSP_W-1:0]  respWords,
  output logic [CMD_W-1:0]  rawStatus,
  output logic [IDX_W-1:0]  reqIndex,
  output logic [WORD_W-1:0] reqArg,
  output logic              loadPending,
  output logic              clkOnly,
  output logic              hasData,
  output logic              autoStop,
  output logic              xferZero,
  output logic              rspGood
);
  logic [WORD_W-1:0] respMem [RSP_WORDS];
  logic              lenMatch;

  always_comb begin
    loadPending = cmdReg[CMD_START_BIT];
    clkOnly     = cmdReg[CMD_CLKONLY_BIT];
    hasData     = cmdReg[CMD_DATA_BIT];
    autoStop    = cmdReg[CMD_AUTOSTOP_BIT];
    xferZero    = (xferCount == '0);
    reqIndex    = strobe.selStop ? STOP_INDEX : cmdReg[IDX_W-1:0];
    reqArg      = strobe.selStop ? '0 : argReg;
    lenMatch    = cmdReg[CMD_LONG_BIT] ? (rspLen == LEN_W'(RSP_BYTES))
                                       : (rspLen == LEN_W'(SHORT_BYTES));
    rspGood     = !rspErr && (!cmdReg[CMD_RSP_BIT] || lenMatch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      argReg <= '0;
    end else begin
      if (cmdWrEn && !busy)        cmdReg <= cmdWrData;
      else if (strobe.clearLoad)   cmdReg[CMD_START_BIT] <= 1'b0;
      if (argWrEn && !busy)        argReg <= argWrData;
    end
  end

  // response words: long replies fill every word, short ones only word 0
  for (genvar w = 0; w < RSP_WORDS; w++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        respMem[w] <= '0;
      end else if (strobe.storeRsp && cmdReg[CMD_RSP_BIT]) begin
        if (cmdReg[CMD_LONG_BIT])
          respMem[w] <= rspData[w*WORD_W +: WORD_W];
        else if (w == 0)
          respMem[w] <= rspData[RSP_W-1 -: WORD_W];
        else
          respMem[w] <= '0;
      end
    end
    assign respWords[w*WORD_W +: WORD_W] = respMem[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawStatus <= '0;
    end else begin
      logic [CMD_W-1:0] nextSt;
      nextSt = rawStatus;
      if (statusClrEn) nextSt = nextSt & ~statusClrMask;
      if (strobe.setDone)  nextSt[ST_DONE_BIT]  = 1'b1;
      if (strobe.setNoRsp) nextSt[ST_NORSP_BIT] = 1'b1;
      if (strobe.setAuto)  nextSt[ST_AUTO_BIT]  = 1'b1;
      rawStatus <= nextSt;
    end
  end
endmodule

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer
  import sdc_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64,
  parameter int XFER_W      = 16,
  parameter int RSP_BYTES   = 16,
  localparam int RSP_W      = 8 * RSP_BYTES,
  localparam int LEN_W      = $clog2(RSP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [31:0]       cmdWrData,
  input  logic              argWrEn,
  input  logic [31:0]       argWrData,
  input  logic [XFER_W-1:0] xferCount,
  input  logic              statusClrEn,
  input  logic [31:0]       statusClrMask,
  output logic              reqValid,
  output logic [5:0]        reqIndex,
  output logic [31:0]       reqArg,
  input  logic              rspValid,
  input  logic              rspErr,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic [RSP_W-1:0]  rspData,
  output logic              dmaStart,
  input  logic              dmaDone,
  output logic [31:0]       cmdReg,
  output logic [31:0]       argReg,
  output logic [RSP_W-1:0]  respWords,
  output logic [31:0]       rawStatus,
  output logic              busy
);
  seqStrobeT strobe;
  logic loadPending, clkOnly, hasData, autoStop, xferZero, rspGood;

  sdc_seq_ctrl #(.RSP_TIMEOUT(RSP_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadPending(loadPending), .clkOnly(clkOnly),
    .hasData(hasData), .autoStop(autoStop), .xferZero(xferZero),
    .rspValid(rspValid), .rspGood(rspGood), .dmaDone(dmaDone),
    .strobe(strobe), .reqValid(reqValid), .dmaStart(dmaStart), .busy(busy)
  );

  sdc_seq_datapath #(.RSP_BYTES(RSP_BYTES), .XFER_W(XFER_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .argWrEn(argWrEn), .argWrData(argWrData), .busy(busy),
    .xferCount(xferCount), .strobe(strobe), .rspErr(rspErr),
    .rspLen(rspLen), .rspData(rspData), .statusClrEn(statusClrEn),
    .statusClrMask(statusClrMask), .cmdReg(cmdReg), .argReg(argReg),
    .respWords(respWords), .rawStatus(rawStatus), .reqIndex(reqIndex),
    .reqArg(reqArg), .loadPending(loadPending), .clkOnly(clkOnly),
    .hasData(hasData), .autoStop(autoStop), .xferZero(xferZero),
    .rspGood(rspGood)
  );
endmodule

// File: rtl/sdc_seq_checker.sv
module sdc_seq_checker #(
  parameter int RSP_TIMEOUT = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrEn,
  input logic [31:0] cmdReg,
  input logic [31:0] argReg,
  input logic        busy,
  input logic        reqValid,
  input logic [5:0]  reqIndex,
  input logic [31:0] reqArg,
  input logic        rspValid,
  input logic [31:0] rawStatus
);
  localparam int CNT_W = $clog2(2 * RSP_TIMEOUT + 2);
  localparam logic [31:0] LIVE_BITS = (32'd1 << 14) | (32'd1 << 2) | (32'd1 << 1);
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (reqValid && !rspValid) waitCnt <= waitCnt + 1'b1;
    else waitCnt <= '0;
  end

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReg[31] |=> !cmdReg[31]);

  p_clkonly_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !cmdReg[21]);

  p_stop_request_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqIndex != cmdReg[5:0] || reqArg != argReg))
      |-> (reqIndex == 6'd12 && reqArg == 32'd0));

  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(rawStatus[1]) && $rose(rawStatus[2])));

  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdReg[31] && cmdWrEn) |=> $stable(cmdReg));

  p_wait_bounded_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (waitCnt < CNT_W'(2 * RSP_TIMEOUT)));

  p_status_bits_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus & ~LIVE_BITS) == 32'd0);
endmodule

bind sd_cmd_sequencer sdc_seq_checker #(.RSP_TIMEOUT(RSP_TIMEOUT)) u_seqChk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdReg(cmdReg),
  .argReg(argReg), .busy(busy), .reqValid(reqValid), .reqIndex(reqIndex),
  .reqArg(reqArg), .rspValid(rspValid), .rawStatus(rawStatus)
);

// File: tb/tb_sd_cmd_sequencer.sv
module tb_sd_cmd_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  typedef struct packed {
    logic [31:0] cmd;
    logic [4:0]  len;
    logic        err;
    logic [7:0]  seed;
    logic [2:0]  expSt;   // {auto, done, norsp}
    logic        expReq;
  } vecT;

  localparam vecT VECS [7] = '{
    '{32'h8000_0051, 5'd4,  1'b0, 8'h10, 3'b010, 1'b1},  // short ok
    '{32'h8000_00C2, 5'd16, 1'b0, 8'h40, 3'b010, 1'b1},  // long ok
    '{32'h8000_0051, 5'd16, 1'b0, 8'h70, 3'b001, 1'b1},  // short, wrong length
    '{32'h8000_00C2, 5'd4,  1'b0, 8'h90, 3'b001, 1'b1},  // long, wrong length
    '{32'h8000_0051, 5'd4,  1'b1, 8'hA0, 3'b001, 1'b1},  // bus error
    '{32'h8000_0003, 5'd4,  1'b0, 8'hB0, 3'b010, 1'b1},  // no response expected
    '{32'h8020_0051, 5'd4,  1'b0, 8'hC0, 3'b010, 1'b0}   // clock change only
  };

  logic         clk = 0, rstN = 0;
  logic         cmdWrEn = 0, argWrEn = 0, statusClrEn = 0;
  logic [31:0]  cmdWrData = 0, argWrData = 0, statusClrMask = 0;
  logic [15:0]  xferCount = 16'd1;
  logic         reqValid, busy, dmaStart;
  logic [5:0]   reqIndex;
  logic [31:0]  reqArg, cmdReg, argReg, rawStatus;
  logic         rspValid = 0, rspErr = 0, dmaDone = 0;
  logic [4:0]   rspLen = 0;
  logic [127:0] rspData = 0, respWords;

  int errors = 0, checks = 0;
  int cardDelay = 0, cardLen = 4, busyCnt = 0;
  bit cardErr = 0, cardSilent = 0;
  logic [7:0] cardSeed = 0;
  int reqCount = 0, dmaAtReq = -1;
  logic [5:0]  idxLog [4];
  logic [31:0] argLog [4];

  sd_cmd_sequencer #(.RSP_TIMEOUT(TMO)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .argWrEn(argWrEn), .argWrData(argWrData), .xferCount(xferCount),
    .statusClrEn(statusClrEn), .statusClrMask(statusClrMask),
    .reqValid(reqValid), .reqIndex(reqIndex), .reqArg(reqArg),
    .rspValid(rspValid), .rspErr(rspErr), .rspLen(rspLen), .rspData(rspData),
    .dmaStart(dmaStart), .dmaDone(dmaDone), .cmdReg(cmdReg), .argReg(argReg),
    .respWords(respWords), .rawStatus(rawStatus), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] mkData(input logic [7:0] seed);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) d[127-8*k -: 8] = seed + 8'(k);
    return d;
  endfunction

  function automatic logic [127:0] expResp(input vecT v, input logic [127:0] prev);
    logic [127:0] d;
    d = mkData(v.seed);
    if (v.err || !v.cmd[6] || v.cmd[21]) return prev;
    if (v.cmd[7]) return (v.len == 5'd16) ? d : prev;
    return (v.len == 5'd4) ? {96'd0, d[127:96]} : prev;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // card-side model: answers each request after cardDelay cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (rspValid) begin
        rspValid = 0;
        waitCnt = 0;
      end else if (reqValid) begin
        if (waitCnt == 0) begin
          if (reqCount < 4) begin
            idxLog[reqCount] = reqIndex;
            argLog[reqCount] = reqArg;
          end
          reqCount++;
        end
        waitCnt++;
        if (!cardSilent && waitCnt > cardDelay) begin
          rspValid = 1;
          rspErr = cardErr;
          rspLen = 5'(cardLen);
          rspData = mkData(cardSeed);
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  // DMA model: done pulse three cycles after start is seen
  initial begin
    forever begin
      @(negedge clk);
      if (dmaDone) dmaDone = 0;
      else if (dmaStart) begin
        if (dmaAtReq < 0) dmaAtReq = reqCount;
        repeat (2) @(negedge clk);
        dmaDone = 1;
      end
    end
  end

  task automatic runCmd(input logic [31:0] cmd);
    reqCount = 0;
    dmaAtReq = -1;
    @(negedge clk);
    cmdWrData = cmd;
    cmdWrEn = 1;
    @(negedge clk);
    cmdWrEn = 0;
    busyCnt = 0;
    while (busy && busyCnt < 1000) begin
      busyCnt++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic clearStatus(input logic [31:0] mask);
    @(negedge clk);
    statusClrMask = mask;
    statusClrEn = 1;
    @(negedge clk);
    statusClrEn = 0;
  endtask

  task automatic writeArg(input logic [31:0] a);
    @(negedge clk);
    argWrData = a;
    argWrEn = 1;
    @(negedge clk);
    argWrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired (R9 busy never ended) actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] prevResp;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state, R11 and R9
    check(rawStatus == 0 && respWords == 0 && cmdReg == 0 && argReg == 0,
          "R11 reset state", {rawStatus, cmdReg, argReg, 32'd0}, 0);
    check(!busy && !reqValid && !dmaStart, "R9 idle after reset",
          {busy, reqValid, dmaStart}, 0);

    // table of vectors: R1 R3 R4 R5 R6 R12
    writeArg(32'hCAFE_0042);
    foreach (VECS[i]) begin
      vecT v = VECS[i];
      prevResp = respWords;
      clearStatus(32'hFFFF_FFFF);
      cardLen = int'(v.len);
      cardErr = v.err;
      cardSeed = v.seed;
      runCmd(v.cmd);
      check(rawStatus == {17'd0, v.expSt[2], 11'd0, v.expSt[1:0], 1'b0},
            $sformatf("R3 R6 R12 status vec %0d", i), rawStatus,
            {17'd0, v.expSt[2], 11'd0, v.expSt[1:0], 1'b0});
      check(respWords == expResp(v, prevResp),
            $sformatf("R4 R5 R6 response vec %0d", i), respWords, expResp(v, prevResp));
      check(reqCount == int'(v.expReq), $sformatf("R3 request count vec %0d", i),
            reqCount, v.expReq);
      if (v.expReq)
        check(idxLog[0] == v.cmd[5:0] && argLog[0] == 32'hCAFE_0042,
              $sformatf("R1 request fields vec %0d", i), {idxLog[0], argLog[0]},
              {v.cmd[5:0], 32'hCAFE_0042});
      check(cmdReg == (v.cmd & 32'h7FFF_FFFF), $sformatf("R2 start cleared vec %0d", i),
            cmdReg, v.cmd & 32'h7FFF_FFFF);
    end

    // R7 R8: auto stop after data phase with zero remaining count
    clearStatus(32'hFFFF_FFFF);
    writeArg(32'h1234_5678);
    cardErr = 0; cardLen = 4; cardSeed = 8'h20;
    xferCount = 0;
    runCmd(32'h8000_1251);
    check(reqCount == 2 && idxLog[0] == 6'd17 && argLog[0] == 32'h1234_5678,
          "R7 user request first", {reqCount, idxLog[0], argLog[0]}, {32'd2, 6'd17, 32'h1234_5678});
    check(idxLog[1] == 6'd12 && argLog[1] == 0, "R7 stop request index/arg",
          {idxLog[1], argLog[1]}, {6'd12, 32'd0});
    check(dmaAtReq == 1, "R8 data phase between user and stop", dmaAtReq, 1);
    check(rawStatus == 32'h0000_4004, "R7 auto done status", rawStatus, 32'h0000_4004);
    check(cmdReg == 32'h0000_1251 && argReg == 32'h1234_5678, "R7 command restored",
          {cmdReg, argReg}, {32'h0000_1251, 32'h1234_5678});

    // R11 write-one-to-clear of a single bit
    clearStatus(32'h0000_0004);
    check(rawStatus == 32'h0000_4000, "R11 clear bit 2 only", rawStatus, 32'h0000_4000);

    // R7 no stop when count is non-zero
    clearStatus(32'hFFFF_FFFF);
    xferCount = 16'd5;
    runCmd(32'h8000_1251);
    check(reqCount == 1 && dmaAtReq == 1, "R7 R8 no stop with count left",
          {reqCount, dmaAtReq}, {32'd1, 32'd1});
    check(rawStatus == 32'h0000_0004, "R7 no auto done bit", rawStatus, 32'h0000_0004);

    // R10 timeout
    clearStatus(32'hFFFF_FFFF);
    cardSilent = 1;
    runCmd(32'h8000_0051);
    cardSilent = 0;
    check(rawStatus == 32'h0000_0002, "R10 timeout sets no-response", rawStatus, 32'h2);
    check(busyCnt == TMO + 1, "R10 busy length on timeout", busyCnt, TMO + 1);

    // R9: writes while busy are ignored
    clearStatus(32'hFFFF_FFFF);
    cardDelay = 6;
    reqCount = 0;
    @(negedge clk);
    cmdWrData = 32'h8000_0045; cmdWrEn = 1;
    @(negedge clk);
    cmdWrEn = 0;
    check(busy == 1, "R9 busy after start", busy, 1);
    @(negedge clk);
    cmdWrData = 32'h8000_00C9; cmdWrEn = 1;
    argWrData = 32'hDEAD_BEEF; argWrEn = 1;
    @(negedge clk);
    cmdWrEn = 0; argWrEn = 0;
    busyCnt = 0;
    while (busy && busyCnt < 1000) begin
      busyCnt++;
      @(negedge clk);
    end
    @(negedge clk);
    check(cmdReg == 32'h0000_0045 && argReg == 32'h1234_5678, "R9 busy writes dropped",
          {cmdReg, argReg}, {32'h0000_0045, 32'h1234_5678});
    check(reqCount == 1 && rawStatus == 32'h4, "R9 single command ran",
          {reqCount, rawStatus}, {32'd1, 32'h4});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule